// File: doc/BRIEF.md
# Thread Context Flit Packetizer

This block moves a thread's architectural state between a per-core register file and the on-chip network during hardware thread migration. On the sending core, an unload request names a context slot, a destination core and the thread's native core. The block then reads the slot through two 64-bit read ports and emits one 128-bit flit per cycle: a header flit first, then the context itself. On the receiving core, the block accepts flits, takes the routing fields from the header, and writes each following flit into a chosen slot through two 64-bit write ports. Once the last word has been written, it signals that the context can resume.

The context holds sixteen 64-bit general registers, sixteen 128-bit floating-point registers, the program counter and one special register. In the slot's 64-bit word space, general register g is word g. Floating-point register f is word 16+2f (low half) and word 17+2f (high half). The program counter is word 48 and the special register is word 49. The packet therefore has one header flit and 25 data flits, 26 flits in total. When nothing stalls, serialization costs exactly 26 cycles in each direction. The destination pipeline re-inserts the thread 3 cycles after the context is marked valid. That step is outside this block.

Top module: `ctx_flit_packer`

## Requirements
- R1: The first flit of every outgoing packet is the header. Bits [7:0] hold the destination core, [15:8] the sending core (`core_id_i`), [23:16] the native core and [31:24] the total flit count (26). Bits [127:32] are zero.
- R2: Outgoing data flit k (1 to 24) carries slot word 2k-2 in bits [63:0] and word 2k-1 in bits [127:64].
- R3: Outgoing flit 25 carries the low 32 bits of word 48 (program counter) in bits [31:0] and the low 32 bits of word 49 (special register) in bits [95:64]. Every other bit is zero, whatever the register file holds.
- R4: With `tx_ready_i` held high, the header is presented two cycles after the accepted start. The 26 flits then occupy 26 consecutive cycles.
- R5: While `tx_valid_o` is high and `tx_ready_i` is low, the presented flit stays valid and unchanged. No flit is lost or repeated.
- R6: A start request while `unload_busy_o` is high is ignored. The current stream is unchanged and no further packet follows it.
- R7: `unload_done_o` is high for exactly the one cycle that follows the handshake of flit 25.
- R8: On the load side, the first accepted flit is taken as a header. `ctx_native_o` and `ctx_src_o` take its bits [23:16] and [15:8]. Each accepted data flit k is written one cycle later to `load_slot_i` (sampled with the header), using the word pairing of R2.
- R9: The write for flit 25 zero-extends bits [31:0] into word 48 and bits [95:64] into word 49. All other bits of that flit are dropped.
- R10: `ctx_valid_o` pulses for one cycle, in the cycle after the write of words 48 and 49, and at no other time.
- R11: During and directly after reset, `tx_valid_o`, `unload_busy_o`, `unload_done_o`, `wr_en_o` and `ctx_valid_o` are low.
- R12: From the first clock after reset, `rx_ready_o` is high, so loading never back-pressures the network.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_id_i | input | 8 | Identity of this core, placed in outgoing headers |
| unload_start_i | input | 1 | Request to send a context |
| unload_slot_i | input | 2 | Slot to send |
| unload_dst_i | input | 8 | Destination core |
| unload_native_i | input | 8 | Native core of the thread |
| unload_busy_o | output | 1 | A packet is being sent |
| unload_done_o | output | 1 | Pulse after the last flit is handed over |
| rd_slot_o | output | 2 | Register file read slot |
| rd_addr0_o | output | 6 | Read word address, lane 0 |
| rd_addr1_o | output | 6 | Read word address, lane 1 |
| rd_data0_i | input | 64 | Read data, lane 0 (combinational) |
| rd_data1_i | input | 64 | Read data, lane 1 (combinational) |
| tx_valid_o | output | 1 | Outgoing flit valid |
| tx_ready_i | input | 1 | Outgoing queue ready |
| tx_flit_o | output | 128 | Outgoing flit |
| rx_valid_i | input | 1 | Incoming flit valid |
| rx_ready_o | output | 1 | Incoming flit accepted |
| rx_flit_i | input | 128 | Incoming flit |
| load_slot_i | input | 2 | Slot to load, sampled with the header |
| wr_en_o | output | 1 | Register file write enable (both lanes) |
| wr_slot_o | output | 2 | Write slot |
| wr_addr0_o | output | 6 | Write word address, lane 0 |
| wr_addr1_o | output | 6 | Write word address, lane 1 |
| wr_data0_o | output | 64 | Write data, lane 0 |
| wr_data1_o | output | 64 | Write data, lane 1 |
| ctx_valid_o | output | 1 | Pulse once the loaded context is complete |
| ctx_native_o | output | 8 | Native core from the last header |
| ctx_src_o | output | 8 | Sending core from the last header |

## Verification
A flit counter that slips by one shifts every word pair. The first data flit compared shows it at once, and a missing or extra handshake at the end shows up as a queue underflow or an unexpected flit. If the valid register drops or reloads during a stall, a changed flit is visible on the very next cycle. On the load side, a wrong index appears as a wrong write address or data in the cycle after acceptance. A misplaced completion pulse appears within one cycle of the final write. Padding faults in either direction are caught on the final flit and in the words written back.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  parameter int WORD_W = 64;
  parameter int FLIT_W = 128;
  parameter int GPR_N  = 16;
  parameter int GPR_W  = 64;
  parameter int FPR_N  = 16;
  parameter int FPR_W  = 128;
  parameter int PC_W   = 32;
  parameter int SPR_W  = 32;
  parameter int CORE_W = 8;
  parameter int CNT_W  = 8;
  parameter int SLOTS  = 4;

  localparam int LANES       = FLIT_W / WORD_W;
  localparam int GPR_WORDS   = GPR_N * GPR_W / WORD_W;
  localparam int FPR_WORDS   = FPR_N * FPR_W / WORD_W;
  localparam int CTX_WORDS   = GPR_WORDS + FPR_WORDS + LANES;
  localparam int CTX_BITS    = CTX_WORDS * WORD_W;
  localparam int DATA_FLITS  = (CTX_BITS + FLIT_W - 1) / FLIT_W;
  localparam int TOTAL_FLITS = DATA_FLITS + 1;
  localparam int LAST_IDX    = TOTAL_FLITS - 1;
  localparam int IDX_W       = $clog2(TOTAL_FLITS);
  localparam int ADDR_W      = $clog2(CTX_WORDS);
  localparam int SLOT_W      = $clog2(SLOTS);
  localparam int SRC_LSB     = CORE_W;
  localparam int NAT_LSB     = 2 * CORE_W;

  typedef struct packed {
    logic [FLIT_W-3*CORE_W-CNT_W-1:0] rsvd;
    logic [CNT_W-1:0]                 count;
    logic [CORE_W-1:0]                native;
    logic [CORE_W-1:0]                src;
    logic [CORE_W-1:0]                dst;
  } hdr_t;

  // lane 0 of the tail flit holds the PC, lane 1 the special register
  function automatic logic [WORD_W-1:0] lane_keep(int lane);
    int w;
    w = (lane == 0) ? PC_W : SPR_W;
    return (WORD_W'(1) << w) - WORD_W'(1);
  endfunction
endpackage

// File: rtl/ctx_tx_ser.sv
module ctx_tx_ser
  import ctx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [CORE_W-1:0] dst_i,
  input  logic [CORE_W-1:0] native_i,
  input  logic [CORE_W-1:0] core_id_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [SLOT_W-1:0] rd_slot_o,
  output logic [ADDR_W-1:0] rd_addr0_o,
  output logic [ADDR_W-1:0] rd_addr1_o,
  input  logic [WORD_W-1:0] rd_data0_i,
  input  logic [WORD_W-1:0] rd_data1_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [FLIT_W-1:0] tx_flit_o
);
  logic              run_q, valid_q, last_q, done_q;
  logic [IDX_W-1:0]  idx_q, pm1;
  logic [SLOT_W-1:0] slot_q;
  hdr_t              hdr_q;
  logic [FLIT_W-1:0] flit_q, nxt;
  logic [ADDR_W-1:0] base;
  logic [LANES-1:0][WORD_W-1:0] rd_lane, pad_lane;
  logic adv, is_last;

  assign busy_o  = run_q | valid_q;
  assign adv     = run_q & (~valid_q | tx_ready_i);
  assign is_last = (idx_q == IDX_W'(LAST_IDX));
  assign pm1     = idx_q - IDX_W'(1);
  assign base    = (idx_q == '0) ? '0 : ADDR_W'({pm1, 1'b0});

  assign rd_slot_o  = slot_q;
  assign rd_addr0_o = base;
  assign rd_addr1_o = base + ADDR_W'(1);
  assign rd_lane    = {rd_data1_i, rd_data0_i};

  for (genvar l = 0; l < LANES; l++) begin : g_pad
    assign pad_lane[l] = rd_lane[l] & lane_keep(l);
  end

  always_comb begin
    if (idx_q == '0)  nxt = hdr_q;
    else if (is_last) nxt = pad_lane;
    else              nxt = rd_lane;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
      idx_q   <= '0;
      slot_q  <= '0;
      hdr_q   <= '0;
      flit_q  <= '0;
    end else begin
      done_q <= valid_q & tx_ready_i & last_q;
      if (start_i && !busy_o) begin
        run_q  <= 1'b1;
        idx_q  <= '0;
        slot_q <= slot_i;
        hdr_q  <= '{rsvd: '0, count: CNT_W'(TOTAL_FLITS), native: native_i,
                    src: core_id_i, dst: dst_i};
      end
      if (adv) begin
        flit_q  <= nxt;
        valid_q <= 1'b1;
        last_q  <= is_last;
        idx_q   <= idx_q + IDX_W'(1);
        if (is_last) run_q <= 1'b0;
      end else if (tx_ready_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign tx_valid_o = valid_q;
  assign tx_flit_o  = flit_q;
  assign done_o     = done_q;
endmodule

// File: rtl/ctx_rx_deser.sv
module ctx_rx_deser
  import ctx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic [FLIT_W-1:0] rx_flit_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              wr_en_o,
  output logic [SLOT_W-1:0] wr_slot_o,
  output logic [ADDR_W-1:0] wr_addr0_o,
  output logic [ADDR_W-1:0] wr_addr1_o,
  output logic [WORD_W-1:0] wr_data0_o,
  output logic [WORD_W-1:0] wr_data1_o,
  output logic              ctx_valid_o,
  output logic [CORE_W-1:0] ctx_native_o,
  output logic [CORE_W-1:0] ctx_src_o
);
  logic              rdy_q, in_pkt_q, wr_q, fin_q, cv_q, acc, is_last;
  logic [IDX_W-1:0]  idx_q, pm1;
  logic [SLOT_W-1:0] slot_q;
  logic [CORE_W-1:0] nat_q, src_q;
  logic [ADDR_W-1:0] base, a0_q;
  logic [LANES-1:0][WORD_W-1:0] in_lane, keep_lane, d_q;

  assign acc     = rx_valid_i & rdy_q;
  assign is_last = (idx_q == IDX_W'(LAST_IDX));
  assign pm1     = idx_q - IDX_W'(1);
  assign base    = ADDR_W'({pm1, 1'b0});
  assign in_lane = rx_flit_i;

  for (genvar l = 0; l < LANES; l++) begin : g_keep
    assign keep_lane[l] = is_last ? (in_lane[l] & lane_keep(l)) : in_lane[l];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q    <= 1'b0;
      in_pkt_q <= 1'b0;
      wr_q     <= 1'b0;
      fin_q    <= 1'b0;
      cv_q     <= 1'b0;
      idx_q    <= '0;
      slot_q   <= '0;
      nat_q    <= '0;
      src_q    <= '0;
      a0_q     <= '0;
      d_q      <= '0;
    end else begin
      rdy_q <= 1'b1;
      wr_q  <= 1'b0;
      fin_q <= 1'b0;
      cv_q  <= fin_q;
      if (acc) begin
        if (!in_pkt_q) begin
          in_pkt_q <= 1'b1;
          idx_q    <= IDX_W'(1);
          slot_q   <= slot_i;
          nat_q    <= rx_flit_i[NAT_LSB +: CORE_W];
          src_q    <= rx_flit_i[SRC_LSB +: CORE_W];
        end else begin
          wr_q  <= 1'b1;
          a0_q  <= base;
          d_q   <= keep_lane;
          idx_q <= idx_q + IDX_W'(1);
          if (is_last) begin
            in_pkt_q <= 1'b0;
            fin_q    <= 1'b1;
          end
        end
      end
    end
  end

  assign rx_ready_o   = rdy_q;
  assign wr_en_o      = wr_q;
  assign wr_slot_o    = slot_q;
  assign wr_addr0_o   = a0_q;
  assign wr_addr1_o   = a0_q + ADDR_W'(1);
  assign wr_data0_o   = d_q[0];
  assign wr_data1_o   = d_q[1];
  assign ctx_valid_o  = cv_q;
  assign ctx_native_o = nat_q;
  assign ctx_src_o    = src_q;
endmodule

// File: rtl/ctx_flit_packer.sv
module ctx_flit_packer
  import ctx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CORE_W-1:0] core_id_i,
  input  logic              unload_start_i,
  input  logic [SLOT_W-1:0] unload_slot_i,
  input  logic [CORE_W-1:0] unload_dst_i,
  input  logic [CORE_W-1:0] unload_native_i,
  output logic              unload_busy_o,
  output logic              unload_done_o,
  output logic [SLOT_W-1:0] rd_slot_o,
  output logic [ADDR_W-1:0] rd_addr0_o,
  output logic [ADDR_W-1:0] rd_addr1_o,
  input  logic [WORD_W-1:0] rd_data0_i,
  input  logic [WORD_W-1:0] rd_data1_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [FLIT_W-1:0] tx_flit_o,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic [FLIT_W-1:0] rx_flit_i,
  input  logic [SLOT_W-1:0] load_slot_i,
  output logic              wr_en_o,
  output logic [SLOT_W-1:0] wr_slot_o,
  output logic [ADDR_W-1:0] wr_addr0_o,
  output logic [ADDR_W-1:0] wr_addr1_o,
  output logic [WORD_W-1:0] wr_data0_o,
  output logic [WORD_W-1:0] wr_data1_o,
  output logic              ctx_valid_o,
  output logic [CORE_W-1:0] ctx_native_o,
  output logic [CORE_W-1:0] ctx_src_o
);
  ctx_tx_ser u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (unload_start_i),
    .slot_i     (unload_slot_i),
    .dst_i      (unload_dst_i),
    .native_i   (unload_native_i),
    .core_id_i  (core_id_i),
    .busy_o     (unload_busy_o),
    .done_o     (unload_done_o),
    .rd_slot_o  (rd_slot_o),
    .rd_addr0_o (rd_addr0_o),
    .rd_addr1_o (rd_addr1_o),
    .rd_data0_i (rd_data0_i),
    .rd_data1_i (rd_data1_i),
    .tx_valid_o (tx_valid_o),
    .tx_ready_i (tx_ready_i),
    .tx_flit_o  (tx_flit_o)
  );

  ctx_rx_deser u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_valid_i   (rx_valid_i),
    .rx_ready_o   (rx_ready_o),
    .rx_flit_i    (rx_flit_i),
    .slot_i       (load_slot_i),
    .wr_en_o      (wr_en_o),
    .wr_slot_o    (wr_slot_o),
    .wr_addr0_o   (wr_addr0_o),
    .wr_addr1_o   (wr_addr1_o),
    .wr_data0_o   (wr_data0_o),
    .wr_data1_o   (wr_data1_o),
    .ctx_valid_o  (ctx_valid_o),
    .ctx_native_o (ctx_native_o),
    .ctx_src_o    (ctx_src_o)
  );
endmodule

// File: rtl/ctx_flit_packer_chk.sv
module ctx_flit_packer_chk
  import ctx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              unload_start_i,
  input logic              unload_busy_o,
  input logic              unload_done_o,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic [FLIT_W-1:0] tx_flit_o,
  input logic              rx_valid_i,
  input logic              rx_ready_o,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr0_o,
  input logic [WORD_W-1:0] wr_data0_o,
  input logic              ctx_valid_o
);
  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tx_valid_o && tx_ready_i)
      cnt_q <= (cnt_q == IDX_W'(LAST_IDX)) ? '0 : cnt_q + IDX_W'(1);
  end

  p_hdr_count_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && cnt_q == '0) |-> tx_flit_o[3*CORE_W +: CNT_W] == CNT_W'(TOTAL_FLITS));

  p_tail_pad_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && cnt_q == IDX_W'(LAST_IDX)) |->
      (tx_flit_o[WORD_W-1:PC_W] == '0 && tx_flit_o[FLIT_W-1:WORD_W+SPR_W] == '0));

  p_hold_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_flit_o)));

  p_busy_on_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unload_start_i && !unload_busy_o) |=> unload_busy_o);

  p_done_after_tail_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unload_done_o |-> ($past(tx_valid_o && tx_ready_i) && $past(cnt_q) == IDX_W'(LAST_IDX)));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unload_done_o |=> !unload_done_o);

  p_wr_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(rx_valid_i && rx_ready_o));

  p_pc_zext_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_addr0_o == ADDR_W'(CTX_WORDS - LANES)) |-> wr_data0_o[WORD_W-1:PC_W] == '0);

  p_ctx_after_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctx_valid_o |-> $past(wr_en_o));

  p_ctx_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctx_valid_o |=> !ctx_valid_o);
endmodule

bind ctx_flit_packer ctx_flit_packer_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .unload_start_i (unload_start_i),
  .unload_busy_o  (unload_busy_o),
  .unload_done_o  (unload_done_o),
  .tx_valid_o     (tx_valid_o),
  .tx_ready_i     (tx_ready_i),
  .tx_flit_o      (tx_flit_o),
  .rx_valid_i     (rx_valid_i),
  .rx_ready_o     (rx_ready_o),
  .wr_en_o        (wr_en_o),
  .wr_addr0_o     (wr_addr0_o),
  .wr_data0_o     (wr_data0_o),
  .ctx_valid_o    (ctx_valid_o)
);

// File: tb/sim_ctx_flit_packer.sv
module sim_ctx_flit_packer;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0]   core_id = 8'h02;
  logic         start = 1'b0;
  logic [1:0]   uslot = 2'd0;
  logic [7:0]   udst = 8'h0, unat = 8'h0;
  logic         busy, done;
  logic [1:0]   rd_slot;
  logic [5:0]   ra0, ra1;
  logic [63:0]  rd0, rd1;
  logic         tx_valid, tx_ready = 1'b1;
  logic [127:0] tx_flit;
  logic         rx_valid = 1'b0, rx_ready;
  logic [127:0] rx_flit = '0;
  logic [1:0]   lslot = 2'd3;
  logic         wr_en;
  logic [1:0]   wr_slot;
  logic [5:0]   wa0, wa1;
  logic [63:0]  wd0, wd1;
  logic         ctx_valid;
  logic [7:0]   ctx_nat, ctx_src;

  ctx_flit_packer u0 (
    .clk_i(clk), .rst_ni(rst_n), .core_id_i(core_id),
    .unload_start_i(start), .unload_slot_i(uslot), .unload_dst_i(udst),
    .unload_native_i(unat), .unload_busy_o(busy), .unload_done_o(done),
    .rd_slot_o(rd_slot), .rd_addr0_o(ra0), .rd_addr1_o(ra1),
    .rd_data0_i(rd0), .rd_data1_i(rd1),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_flit_o(tx_flit),
    .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .rx_flit_i(rx_flit),
    .load_slot_i(lslot), .wr_en_o(wr_en), .wr_slot_o(wr_slot),
    .wr_addr0_o(wa0), .wr_addr1_o(wa1), .wr_data0_o(wd0), .wr_data1_o(wd1),
    .ctx_valid_o(ctx_valid), .ctx_native_o(ctx_nat), .ctx_src_o(ctx_src)
  );

  function automatic logic [63:0] pat(int s, int w);
    return {4'hC, 2'b00, 2'(s), 8'(w), 16'hBEEF, 8'(w * 7), 8'hA5, 16'(w * 257 + s)};
  endfunction

  function automatic logic [127:0] exp_flit(int s, int k, logic [7:0] dst, logic [7:0] nat);
    logic [63:0] lo, hi;
    if (k == 0) return {96'b0, 8'd26, nat, 8'h02, dst};
    lo = pat(s, 2 * k - 2);
    hi = pat(s, 2 * k - 1);
    if (k == 25) return {32'b0, hi[31:0], 32'b0, lo[31:0]};
    return {hi, lo};
  endfunction

  // register file model: combinational read, write at the clock edge
  logic [63:0] rf [0:3][0:49];
  assign rd0 = rf[rd_slot][ra0];
  assign rd1 = rf[rd_slot][ra1];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 4; s++)
        for (int w = 0; w < 50; w++) rf[s][w] <= pat(s, w);
    end else if (wr_en) begin
      rf[wr_slot][wa0] <= wd0;
      rf[wr_slot][wa1] <= wd1;
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // reference model state
  logic [127:0] tx_exp[$];
  logic [127:0] cap[$];
  bit           cap_en = 0;
  int cyc = 0, tx_cnt = 0, hs_first = -1, hs_last = -1, start_cyc = -1, extra = 0, ctx_cnt = 0;
  bit done_exp = 0, stall_q = 0;
  logic [127:0] stall_flit;
  bit rxm_in = 0, wp = 0, wp_last = 0, cp = 0;
  int rxm_idx = 0;
  logic [1:0]  rxm_slot, e_slot;
  logic [5:0]  ea0, ea1;
  logic [63:0] ed0, ed1;

  always @(negedge clk) begin
    #4;
    if (!rst_n) begin
      tx_cnt = 0; done_exp = 0; stall_q = 0; rxm_in = 0; wp = 0; wp_last = 0; cp = 0;
    end else begin
      // transmit side
      chk(done == done_exp, "R7 done pulse", 128'(done), 128'(done_exp));
      if (stall_q)
        chk(tx_valid && tx_flit == stall_flit, "R5 stall hold", tx_flit, stall_flit);
      done_exp = 0;
      if (tx_valid && tx_ready) begin
        if (tx_exp.size() == 0) begin
          extra++;
          chk(0, "R6 unexpected flit", tx_flit, '0);
        end else begin
          chk(tx_flit == tx_exp[0], tx_cnt == 0 ? "R1 header" : (tx_cnt == 25 ? "R3 tail" : "R2 data"),
              tx_flit, tx_exp[0]);
          void'(tx_exp.pop_front());
        end
        if (cap_en) cap.push_back(tx_flit);
        if (tx_cnt == 0) hs_first = cyc;
        if (tx_cnt == 25) begin
          hs_last = cyc; done_exp = 1; tx_cnt = 0;
        end else tx_cnt++;
      end
      stall_q = tx_valid && !tx_ready;
      stall_flit = tx_flit;
      if (start && !busy) start_cyc = cyc;
      // receive side
      if (wp)
        chk(wr_en && wr_slot == e_slot && wa0 == ea0 && wa1 == ea1 && wd0 == ed0 && wd1 == ed1,
            wp_last ? "R9 tail write" : "R8 write", {wd1, wd0}, {ed1, ed0});
      else
        chk(!wr_en, "R8 no write", 128'(wr_en), 0);
      chk(ctx_valid == cp, "R10 ctx valid", 128'(ctx_valid), 128'(cp));
      if (ctx_valid) ctx_cnt++;
      cp = wp_last; wp = 0; wp_last = 0;
      if (rx_valid && rx_ready) begin
        if (!rxm_in) begin
          rxm_in = 1; rxm_idx = 1; rxm_slot = lslot;
        end else begin
          wp = 1; e_slot = rxm_slot;
          ea0 = 6'(2 * (rxm_idx - 1)); ea1 = ea0 + 6'd1;
          if (rxm_idx == 25) begin
            ed0 = {32'b0, rx_flit[31:0]}; ed1 = {32'b0, rx_flit[95:64]};
            wp_last = 1; rxm_in = 0;
          end else begin
            ed0 = rx_flit[63:0]; ed1 = rx_flit[127:64];
          end
          rxm_idx++;
        end
      end
    end
    cyc++;
    if (cyc > 20000) begin
      chk(0, "watchdog", 128'(cyc), 0);
      finish_run();
    end
  end

  int rdy_mode = 0;
  initial begin
    logic [7:0] lfsr = 8'h5B;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tx_ready = (rdy_mode == 0) ? 1'b1 : lfsr[0] | lfsr[2];
    end
  end

  task automatic do_start(int s, logic [7:0] dst, logic [7:0] nat, bit expect_pkt);
    if (expect_pkt)
      for (int k = 0; k < 26; k++) tx_exp.push_back(exp_flit(s, k, dst, nat));
    @(negedge clk);
    start = 1; uslot = 2'(s); udst = dst; unat = nat;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_tx();
    while (tx_exp.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [127:0] lb[$];
    logic [63:0] w48, w49;
    repeat (3) @(negedge clk);
    #1;
    chk(!tx_valid && !busy && !done && !wr_en && !ctx_valid, "R11 reset state",
        {tx_valid, busy, done, wr_en, ctx_valid}, 0);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(!tx_valid && !busy && !wr_en && !ctx_valid, "R11 after reset", {tx_valid, busy, wr_en, ctx_valid}, 0);
    repeat (2) @(negedge clk);
    #1;
    chk(rx_ready, "R12 rx ready", 128'(rx_ready), 1);

    // A: full rate unload of slot 1, captured for loopback
    cap_en = 1;
    do_start(1, 8'h03, 8'h07, 1);
    wait_tx();
    cap_en = 0;
    chk(hs_first == start_cyc + 2, "R4 header latency", 128'(hs_first), 128'(start_cyc + 2));
    chk(hs_last == start_cyc + 27, "R4 back-to-back", 128'(hs_last), 128'(start_cyc + 27));
    chk(cap.size() == 26, "R4 flit count", 128'(cap.size()), 26);

    // B: unload of slot 2 under back-pressure, with a start while busy
    rdy_mode = 1;
    do_start(2, 8'h11, 8'h22, 1);
    repeat (8) @(negedge clk);
    #1;
    chk(busy, "R6 busy mid-packet", 128'(busy), 1);
    do_start(0, 8'h99, 8'h44, 0);
    wait_tx();
    repeat (40) @(negedge clk);
    chk(extra == 0, "R6 start ignored", 128'(extra), 0);
    rdy_mode = 0;

    // C: loop the captured packet back into slot 3 with junk in the tail padding
    foreach (cap[i]) lb.push_back(cap[i]);
    lb[25][63:32]  = 32'hDEAD_BEEF;
    lb[25][127:96] = 32'hFACE_0FF1;
    for (int i = 0; i < 26; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_flit = lb[i]; lslot = 2'd3;
      if (i % 5 == 4) begin
        @(negedge clk);
        rx_valid = 0;
      end
    end
    @(negedge clk);
    rx_valid = 0;
    repeat (4) @(negedge clk);
    #1;
    chk(ctx_nat == 8'h07, "R8 native core", 128'(ctx_nat), 128'(8'h07));
    chk(ctx_src == 8'h02, "R8 source core", 128'(ctx_src), 128'(8'h02));
    chk(ctx_cnt == 1, "R10 one ctx pulse", 128'(ctx_cnt), 1);
    for (int w = 0; w < 48; w++)
      chk(rf[3][w] == pat(1, w), "R8 loaded word", 128'(rf[3][w]), 128'(pat(1, w)));
    w48 = pat(1, 48);
    w49 = pat(1, 49);
    chk(rf[3][48] == {32'b0, w48[31:0]}, "R9 pc word", 128'(rf[3][48]), 128'({32'b0, w48[31:0]}));
    chk(rf[3][49] == {32'b0, w49[31:0]}, "R9 special word", 128'(rf[3][49]), 128'({32'b0, w49[31:0]}));
    chk(rf[1][48] == w48, "R8 source slot untouched", 128'(rf[1][48]), 128'(w48));
    finish_run();
  end
endmodule